// File: doc/BRIEF.md
# Converter Output Word Formatter

This block sits between the numeric model of a 12-bit pipelined converter core and the pad cells that drive its output bus. Every sample clock it takes one signed raw conversion result that is wider than the output word. It limits the value to the 12-bit span, flags any sample that had to be limited, and delays the word and its flag together through a fixed ten-cycle pipeline. At the output it renders the word in one of three number formats.

A small set of control registers is loaded through a plain write strobe, an address and a data byte. One register picks the output format and can turn the pad drivers off. The other selects the power state. In power-down the drivers are off. In both power-down and standby the delay line stops accepting samples. On return to normal running, the output is flagged invalid until the delay line holds ten fresh samples again. High impedance is expressed as a pad-enable output (`pad_oe`) for the pad cells.

Top module: `adc_fmt_top`

## Requirements
- R1: A raw sample above +2047 gives the most-positive code and a raw sample below -2048 gives the most-negative code, with `pad_ovr` = 1 in both cases.
- R2: Raw samples of exactly -2048, 0 and +2047 pass unchanged with `pad_ovr` = 0.
- R3: A sample presented on `raw_in` during clock cycle t appears on `pad_data` and `pad_ovr` during cycle t+10. Data and flag stay aligned.
- R4: After reset the format is two's complement: -2048 is 0x800, 0 is 0x000 and +2047 is 0x7FF.
- R5: Writing bits [1:0] = 00 to address 0x14 selects offset binary: -2048 is 0x000, 0 is 0x800 and +2047 is 0xFFF.
- R6: Writing bits [1:0] = 10 to address 0x14 selects Gray code, g = b ^ (b >> 1), where b is the offset-binary word. For example, 0 gives 0xC00 and +2047 gives 0x800.
- R7: A write of 11 to the format field (address 0x14, bits [1:0]) is ignored, and the previous format stays in force.
- R8: Bit 4 of address 0x14, when set, drives `pad_oe` low. Clearing it drives `pad_oe` high again.
- R9: Writing 01 to bits [1:0] of address 0x08 (power-down) drives `pad_oe` low and `out_valid` low.
- R10: Writing 10 to bits [1:0] of address 0x08 (standby) keeps `pad_oe` high, drives `out_valid` low and holds `pad_data` constant while `raw_in` changes.
- R11: After writing 00 to address 0x08 from power-down or standby, `out_valid` stays low until ten new samples have entered. The first valid word is the first sample taken after the return.
- R12: A write of 11 to the power field (address 0x08, bits [1:0]) is ignored.
- R13: During and after reset, `pad_oe` is 1, `out_valid` is 0, `pad_data` is 0x000, `pad_ovr` is 0 and the power state is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | IN_W | Signed raw conversion result |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| pad_data | output | OUT_W | Formatted output word |
| pad_ovr | output | 1 | Overrange flag aligned with `pad_data` |
| pad_oe | output | 1 | Pad driver enable; 0 means high impedance |
| out_valid | output | 1 | Output word belongs to a sample taken in normal mode |

## Verification
The bench uses the default parameters: a 16-bit raw input, a 12-bit word and a latency of 10. The 16-bit input reaches values thousands of codes beyond either end of the 12-bit span, as well as the exact boundary codes, so both limiting branches and the boundary cases can be exercised. With a latency of 10, the bench can probe the refill window directly: `out_valid` must still be low on the ninth cycle after wake-up and high on the tenth, carrying the first post-wake sample.

// File: rtl/adc_fmt_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the output formatter: format codes, power states
// and the two control register addresses decoded by the register bank.
package adc_fmt_pkg;
    typedef enum logic [1:0] {
        FMT_OFFSET = 2'b00,
        FMT_TWOS   = 2'b01,
        FMT_GRAY   = 2'b10
    } fmt_e;

    typedef enum logic [1:0] {
        PWR_RUN  = 2'b00,
        PWR_DOWN = 2'b01,
        PWR_STBY = 2'b10
    } pwr_e;

    localparam logic [7:0] ADDR_PWR = 8'h08;
    localparam logic [7:0] ADDR_OUT = 8'h14;
endpackage

// File: rtl/adc_fmt_clamp.sv
`timescale 1ns/1ps
// Limits a wide signed sample to the OUT_W-bit two's complement span and
// flags samples that were limited. Assumes IN_W > OUT_W. Purely combinational.
module adc_fmt_clamp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic signed [IN_W-1:0]  raw,
    output logic        [OUT_W-1:0] word,
    output logic                    ovr
);
    localparam int EXT = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] HI = {{EXT{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] LO = {{EXT{1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic [OUT_W-1:0] W_MAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] W_MIN = {1'b1, {(OUT_W-1){1'b0}}};

    // Select the limited word and raise the flag outside the span.
    always_comb begin
        if (raw > HI) begin
            word = W_MAX;
            ovr  = 1'b1;
        end else if (raw < LO) begin
            word = W_MIN;
            ovr  = 1'b1;
        end else begin
            word = raw[OUT_W-1:0];
            ovr  = 1'b0;
        end
    end

    // A flagged word must sit on one of the two rails.
    always_comb begin
        if (ovr) AST_CLAMP_EDGE: assert (word == W_MAX || word == W_MIN); // R1
    end
endmodule

// File: rtl/adc_fmt_delay.sv
`timescale 1ns/1ps
// Fixed-latency delay line for word plus flag. Shifts only while run is
// high; each stage carries a valid bit that is cleared whenever run is
// low, so refilling takes LAT accepted samples. Assumes LAT >= 2.
module adc_fmt_delay #(
    parameter int W   = 13,
    parameter int LAT = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         vld
);
    logic [W-1:0]   stg [LAT];
    logic [LAT-1:0] vbits;

    for (genvar k = 0; k < LAT; k++) begin : g_stage
        if (k == 0) begin : g_head
            // Capture the incoming sample into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)   stg[k] <= '0;
                else if (run) stg[k] <= din;
            end
        end else begin : g_body
            // Advance the previous stage by one position.
            always_ff @(posedge clk) begin
                if (!rst_n)   stg[k] <= '0;
                else if (run) stg[k] <= stg[k-1];
            end
        end
    end

    // Track which stages hold samples accepted since the last stall.
    always_ff @(posedge clk) begin
        if (!rst_n)    vbits <= '0;
        else if (!run) vbits <= '0;
        else           vbits <= {vbits[LAT-2:0], 1'b1};
    end

    assign dout = stg[LAT-1];
    assign vld  = vbits[LAT-1];

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(dout)); // R10
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !vld); // R11
endmodule

// File: rtl/adc_fmt_encode.sv
`timescale 1ns/1ps
// Renders a two's complement word as offset binary, two's complement or
// Gray code (Gray derived from offset binary). Purely combinational.
module adc_fmt_encode
    import adc_fmt_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  fmt_e             fmt,
    input  logic [OUT_W-1:0] tc,
    output logic [OUT_W-1:0] code
);
    logic [OUT_W-1:0] ob;

    // Offset binary is two's complement with the sign bit inverted.
    always_comb ob = {~tc[OUT_W-1], tc[OUT_W-2:0]};

    // Pick the representation requested by the format field.
    always_comb begin
        case (fmt)
            FMT_OFFSET: code = ob;
            FMT_GRAY:   code = ob ^ (ob >> 1);
            default:    code = tc;
        endcase
    end
endmodule

// File: rtl/adc_fmt_regs.sv
`timescale 1ns/1ps
// Control register bank: output register (format field, driver disable)
// and power register. Writes of the reserved code 11 to a two-bit field
// leave that field unchanged. Synchronous active-low reset.
module adc_fmt_regs
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output fmt_e       fmt,
    output pwr_e       pwr,
    output logic       out_dis
);
    logic unused_bits;
    assign unused_bits = ^{wdata[7:5], wdata[3:2]};

    // Apply register writes, skipping reserved field codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt     <= FMT_TWOS;
            pwr     <= PWR_RUN;
            out_dis <= 1'b0;
        end else if (wr) begin
            if (addr == ADDR_OUT) begin
                out_dis <= wdata[4];
                if (wdata[1:0] != 2'b11) fmt <= fmt_e'(wdata[1:0]);
            end
            if (addr == ADDR_PWR && wdata[1:0] != 2'b11) pwr <= pwr_e'(wdata[1:0]);
        end
    end

    AST_FMT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_OUT && wdata[1:0] == 2'b11) |=> $stable(fmt)); // R7
    AST_PWR_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_PWR && wdata[1:0] == 2'b11) |=> $stable(pwr)); // R12
endmodule

// File: rtl/adc_fmt_top.sv
`timescale 1ns/1ps
// Output formatter top: limit and flag, LAT-cycle delay, format encode,
// control registers and pad enable. The pad cells apply high impedance
// from pad_oe. Assumes IN_W > OUT_W and LAT >= 2.
module adc_fmt_top
    import adc_fmt_pkg::*;
#(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int LAT   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [IN_W-1:0]  raw_in,
    input  logic                    reg_wr,
    input  logic [7:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [OUT_W-1:0]        pad_data,
    output logic                    pad_ovr,
    output logic                    pad_oe,
    output logic                    out_valid
);
    localparam int PW = OUT_W + 1;

    fmt_e             fmt;
    pwr_e             pwr;
    logic             out_dis;
    logic             run;
    logic [OUT_W-1:0] lim_word;
    logic             lim_ovr;
    logic [PW-1:0]    dly_q;
    logic             dly_vld;

    adc_fmt_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .fmt     (fmt),
        .pwr     (pwr),
        .out_dis (out_dis)
    );

    adc_fmt_clamp #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clamp (
        .raw  (raw_in),
        .word (lim_word),
        .ovr  (lim_ovr)
    );

    // The delay line advances only in normal power state.
    assign run = (pwr == PWR_RUN);

    adc_fmt_delay #(.W(PW), .LAT(LAT)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .din   ({lim_ovr, lim_word}),
        .dout  (dly_q),
        .vld   (dly_vld)
    );

    adc_fmt_encode #(.OUT_W(OUT_W)) u_enc (
        .fmt  (fmt),
        .tc   (dly_q[OUT_W-1:0]),
        .code (pad_data)
    );

    // Flag output, driver enable and validity qualified by power state.
    assign pad_ovr   = dly_q[PW-1];
    assign pad_oe    = !out_dis && (pwr != PWR_DOWN);
    assign out_valid = dly_vld && run;
endmodule

// File: tb/test_adc_fmt_top.sv
`timescale 1ns/1ps
module test_adc_fmt_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [15:0] raw_in = '0;
    logic               reg_wr = 1'b0;
    logic [7:0]         reg_addr = '0;
    logic [7:0]         reg_wdata = '0;
    logic [11:0]        pad_data;
    logic               pad_ovr;
    logic               pad_oe;
    logic               out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [1:0] cur_fmt = 2'b01;

    adc_fmt_top i_adc_fmt_top (
        .clk(clk), .rst_n(rst_n), .raw_in(raw_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .pad_data(pad_data), .pad_ovr(pad_ovr), .pad_oe(pad_oe),
        .out_valid(out_valid)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected {flag, code} from the requirements for value v in format f.
    function automatic logic [12:0] model(input int v, input logic [1:0] f);
        int c;
        logic o;
        logic [11:0] tc, ob, g;
        if (v > 2047) begin c = 2047; o = 1'b1; end
        else if (v < -2048) begin c = -2048; o = 1'b1; end
        else begin c = v; o = 1'b0; end
        tc = 12'(c);
        ob = tc ^ 12'h800;
        g  = ob ^ (ob >> 1);
        case (f)
            2'b00:   return {o, ob};
            2'b10:   return {o, g};
            default: return {o, tc};
        endcase
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Drive eight samples then zeros; check each output ten cycles later.
    task automatic stream(input string tag, input int v[8], input bit fresh);
        logic [12:0] e;
        for (int i = 0; i < 18; i++) begin
            if (fresh && (i == 0 || i == 9)) chk({tag, " R11 valid low while refilling"}, 32'(out_valid), 0);
            if (i >= 10) begin
                e = model(v[i-10], cur_fmt);
                chk({tag, " R3 data"}, 32'(pad_data), 32'(e[11:0]));
                chk({tag, " R3 ovr"}, 32'(pad_ovr), 32'(e[12]));
                chk({tag, " R11 valid"}, 32'(out_valid), 1);
            end
            raw_in = (i < 8) ? 16'(v[i]) : 16'sd0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R13 oe", 32'(pad_oe), 1);
        chk("R13 valid", 32'(out_valid), 0);
        chk("R13 data", 32'(pad_data), 0);
        chk("R13 ovr", 32'(pad_ovr), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_twos_default();
        stream("R4 R1 R2 twos", '{-2048, 0, 2047, -2049, 2048, -30000, 30000, 1234}, 1'b1);
    endtask

    task automatic t_offset();
        wr(8'h14, 8'h00); cur_fmt = 2'b00;
        stream("R5 R1 R2 offset", '{-2048, 0, 2047, -5000, 5000, -1, 1, 300}, 1'b0);
    endtask

    task automatic t_gray();
        wr(8'h14, 8'h02); cur_fmt = 2'b10;
        stream("R6 gray", '{0, -2048, 2047, -1, 1, 9999, -9999, 777}, 1'b0);
    endtask

    task automatic t_fmt_reserved();
        wr(8'h14, 8'h03);
        stream("R7 reserved fmt", '{0, 2047, -2048, 5, -6, 100, -100, 3000}, 1'b0);
        wr(8'h14, 8'h01); cur_fmt = 2'b01;
    endtask

    task automatic t_disable();
        wr(8'h14, 8'h11);
        chk("R8 oe low when disabled", 32'(pad_oe), 0);
        wr(8'h14, 8'h01);
        chk("R8 oe back high", 32'(pad_oe), 1);
    endtask

    task automatic t_standby();
        logic [11:0] held;
        wr(8'h08, 8'h02);
        chk("R10 oe kept in standby", 32'(pad_oe), 1);
        chk("R10 valid low in standby", 32'(out_valid), 0);
        held = pad_data;
        for (int i = 0; i < 5; i++) begin
            raw_in = 16'(100 * i + 37);
            @(negedge clk);
        end
        chk("R10 data frozen", 32'(pad_data), 32'(held));
        wr(8'h08, 8'h00);
        stream("R11 wake from standby", '{11, -22, 33, -44, 2100, -2100, 0, 7}, 1'b1);
    endtask

    task automatic t_powerdown();
        wr(8'h08, 8'h01);
        chk("R9 oe low in power-down", 32'(pad_oe), 0);
        chk("R9 valid low in power-down", 32'(out_valid), 0);
        repeat (4) @(negedge clk);
        chk("R9 oe still low", 32'(pad_oe), 0);
        wr(8'h08, 8'h00);
        chk("R9 oe high after wake", 32'(pad_oe), 1);
        stream("R11 wake from power-down", '{-7, 8, -2048, 2047, 4000, -4000, 1, -1}, 1'b1);
    endtask

    task automatic t_pwr_reserved();
        wr(8'h08, 8'h03);
        chk("R12 oe unchanged", 32'(pad_oe), 1);
        chk("R12 valid unchanged", 32'(out_valid), 1);
    endtask

    initial begin
        t_reset();
        t_twos_default();
        t_offset();
        t_gray();
        t_fmt_reserved();
        t_disable();
        t_standby();
        t_powerdown();
        t_pwr_reserved();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule